// File: doc/BRIEF.md
# DDR Write-to-Read Command Sequencer

This block sits inside a DDR SDRAM controller. It decides when a read may follow a write and which extra commands must come first. It keeps a small table with the state of every bank (idle, or open with a known row) and remembers the bank and timing of the most recent write. A read request names a bank and a row. The block compares them with that table and with the last write, then produces one of three command sequences on a per-cycle command bus. The sequences are: a bare READ; PRECHARGE, ACTIVE, READ; or ACTIVE, READ.

Write requests put a WRITE on the bus for an already-open bank. From that point the block counts cycles. No READ leaves the block earlier than BL/2 + 3 cycles after the WRITE, which leaves time for the write burst to drain. A precharge of the bank just written waits a separate write-to-precharge delay. The block also raises a read-issued strobe and a window flag that marks the clock cycles in which the read burst returns data, CL cycles after the READ and BL/2 cycles long. Burst length, CAS latency and the three delays are elaboration parameters.

Top module: `ddr_w2r_seq`

## Requirements
- R1: After a synchronous reset the command bus shows NOP (code 0), `busy`, `rd_issued` and `rd_data_win` are low, and every bank is idle.
- R2: When the block is not busy, `wr_valid` to an open bank puts WRITE (code 1) on the bus in the next cycle, with that bank and its open row. A write to an idle bank is ignored and the bus stays NOP. When `wr_valid` and `rd_valid` arrive in the same cycle, the write is taken and the read is dropped.
- R3: A READ (code 2) appears no sooner than BL/2 + 3 cycles after the cycle that carried the last WRITE. It appears exactly then when the request arrived early enough.
- R4: A read to an open bank whose open row matches issues only READ, at the earliest in the cycle after the request is accepted.
- R5: A read to the bank last written, open with another row, first issues PRECHARGE (code 4) to that bank. This happens in the later of the cycle after acceptance and T_WPD cycles after the WRITE.
- R6: After a PRECHARGE in a sequence, ACTIVE (code 3) for the requested row follows exactly T_RP cycles later. READ follows T_RCDRD cycles after the ACTIVE, or later if R3 requires it.
- R7: A read to a bank other than the last written one, open with another row, issues PRECHARGE in the cycle after acceptance, whatever the write timing.
- R8: A read to an idle bank issues ACTIVE in the cycle after acceptance with no PRECHARGE. READ follows T_RCDRD cycles later, or later under R3.
- R9: `busy` is high from the cycle after a read is accepted until the READ cycle, where it is low. All cycles in between carry NOP except the sequence's own commands. Read and write requests that arrive while busy are dropped.
- R10: `rd_issued` is high in exactly the cycles that carry READ.
- R11: `rd_data_win` is high in each cycle that lies between CL and CL + BL/2 - 1 cycles after a READ cycle.
- R12: The bank table opens a bank with its row on ACTIVE and marks it idle on PRECHARGE. Later reads choose their sequence from that updated state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising-edge active |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write request, sampled when not busy |
| wr_bank | input | $clog2(BANKS) | Bank of the write request |
| rd_valid | input | 1 | Read request, sampled when not busy and no write is requested |
| rd_bank | input | $clog2(BANKS) | Bank of the read request |
| rd_row | input | ROW_W | Row of the read request |
| busy | output | 1 | A read sequence is in progress |
| cmd | output | 3 | Command code: 0 NOP, 1 WRITE, 2 READ, 3 ACTIVE, 4 PRECHARGE |
| cmd_bank | output | $clog2(BANKS) | Bank of the command on the bus |
| cmd_row | output | ROW_W | Row of the command on the bus (valid for WRITE, READ, ACTIVE) |
| rd_issued | output | 1 | High in the cycle a READ is on the bus |
| rd_data_win | output | 1 | High in the cycles the read burst returns data |

## Verification
The bench targets the cases where the write gate and the sequence timing compete. A read that hits the row just written must wait the full BL/2 + 3 gap, and a design that dropped that gate would issue READ in the cycle after acceptance. A row miss on the written bank must delay its PRECHARGE by T_WPD, while a miss on another bank must not. A design that mixed these up would either precharge too early or stall for no reason. Requests sent while busy, and a write and read sent together, are checked for leaking extra commands. Back-to-back hits check that a data window is not cut short by the next READ.

// File: rtl/ddr_w2r_pkg.sv
package ddr_w2r_pkg;

    typedef enum logic [2:0] {
        CMD_NOP   = 3'd0,
        CMD_WRITE = 3'd1,
        CMD_READ  = 3'd2,
        CMD_ACT   = 3'd3,
        CMD_PRE   = 3'd4
    } cmd_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_PRE,
        SQ_ACT,
        SQ_RD
    } seq_st_e;

    // Minimum write-to-read command spacing: the burst needs BL/2 clocks plus margin.
    function automatic int wr2rd_gap(input int bl);
        return bl / 2 + 3;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/w2r_bank_table.sv
module w2r_bank_table
    import ddr_w2r_pkg::*;
#(
    parameter int BANKS  = 4,
    parameter int ROW_W  = 12,
    localparam int BANK_W = $clog2(BANKS)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  cmd_e                          upd_cmd,
    input  logic [BANK_W-1:0]             upd_bank,
    input  logic [ROW_W-1:0]              upd_row,
    input  cmd_e                          cmd_q,
    input  logic [BANK_W-1:0]             cmd_bank_q,
    input  logic [ROW_W-1:0]              cmd_row_q,
    output logic [BANKS-1:0]              open_o,
    output logic [BANKS-1:0][ROW_W-1:0]   rows_o
);

    for (genvar g = 0; g < BANKS; g++) begin : g_bank
        logic             open_r;
        logic [ROW_W-1:0] row_r;

        always_ff @(posedge clk) begin
            if (rst) begin
                open_r <= 1'b0;
                row_r  <= '0;
            end else if (upd_bank == BANK_W'(g)) begin
                if (upd_cmd == CMD_ACT) begin
                    open_r <= 1'b1;
                    row_r  <= upd_row;
                end else if (upd_cmd == CMD_PRE) begin
                    open_r <= 1'b0;
                end
            end
        end

        assign open_o[g] = open_r;
        assign rows_o[g] = row_r;
    end

    AST_READ_OPEN_ROW: assert property (@(posedge clk) disable iff (rst)
        (cmd_q == CMD_READ) |-> (open_o[cmd_bank_q] && rows_o[cmd_bank_q] == cmd_row_q))
        else $error("READ to a bank that is not open on that row"); // R12

    AST_WRITE_OPEN_BANK: assert property (@(posedge clk) disable iff (rst)
        (cmd_q == CMD_WRITE) |-> open_o[cmd_bank_q])
        else $error("WRITE to an idle bank"); // R2

endmodule

// File: rtl/w2r_write_track.sv
module w2r_write_track
    import ddr_w2r_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int TWRD   = 5,
    parameter int T_WPD  = 4,
    localparam int SMAX  = imax(TWRD, T_WPD),
    localparam int SW    = $clog2(SMAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_fire,
    input  logic [BANK_W-1:0] wr_bank,
    input  logic [BANK_W-1:0] tgt_bank,
    input  cmd_e              cmd_q,
    input  logic [BANK_W-1:0] cmd_bank_q,
    output logic              rd_ok,
    output logic              pre_ok
);

    logic [SW-1:0]     since;
    logic [BANK_W-1:0] last_bank;

    // 'since' equals the number of cycles elapsed since the cycle that carried WRITE.
    always_ff @(posedge clk) begin
        if (rst) begin
            since     <= SW'(SMAX);
            last_bank <= '0;
        end else if (wr_fire) begin
            since     <= '0;
            last_bank <= wr_bank;
        end else if (int'(since) < SMAX) begin
            since     <= since + 1'b1;
        end
    end

    // Gates look one cycle ahead: the command is registered at the next edge.
    assign rd_ok  = int'(since) >= TWRD - 1;
    assign pre_ok = (tgt_bank != last_bank) || (int'(since) >= T_WPD - 1);

    AST_WR2RD_GAP: assert property (@(posedge clk) disable iff (rst)
        (cmd_q == CMD_READ) |-> (int'(since) >= TWRD))
        else $error("READ closer than the write-to-read gap"); // R3

    AST_WR2PRE_GAP: assert property (@(posedge clk) disable iff (rst)
        (cmd_q == CMD_PRE && cmd_bank_q == last_bank) |-> (int'(since) >= T_WPD))
        else $error("PRECHARGE of the written bank too soon"); // R5

endmodule

// File: rtl/w2r_read_window.sv
module w2r_read_window #(
    parameter int CL = 2,
    parameter int BL = 4,
    localparam int N = CL + BL / 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rd_fire,
    output logic win
);

    // sh[k] set means a READ was on the bus k cycles ago.
    logic [N-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[N-2:0], rd_fire};
    end

    assign win = |sh[N-1:CL];

endmodule

// File: rtl/w2r_seq_fsm.sv
module w2r_seq_fsm
    import ddr_w2r_pkg::*;
#(
    parameter int BANKS   = 4,
    parameter int ROW_W   = 12,
    parameter int T_RP    = 2,
    parameter int T_RCDRD = 2,
    localparam int BANK_W = $clog2(BANKS),
    localparam int CMAX   = imax(T_RP, T_RCDRD),
    localparam int CW     = $clog2(CMAX + 1)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_valid,
    input  logic [BANK_W-1:0]           wr_bank,
    input  logic                        rd_valid,
    input  logic [BANK_W-1:0]           rd_bank,
    input  logic [ROW_W-1:0]            rd_row,
    input  logic [BANKS-1:0]            open_i,
    input  logic [BANKS-1:0][ROW_W-1:0] rows_i,
    input  logic                        rd_ok,
    input  logic                        pre_ok,
    output cmd_e                        nxt_cmd,
    output logic [BANK_W-1:0]           nxt_bank,
    output logic [ROW_W-1:0]            nxt_row,
    output logic [BANK_W-1:0]           tgt_bank,
    output cmd_e                        cmd_q,
    output logic [BANK_W-1:0]           cmd_bank_q,
    output logic [ROW_W-1:0]            cmd_row_q,
    output logic                        issued_q,
    output logic                        busy
);

    localparam logic [CW-1:0] RP_LD  = CW'(T_RP - 1);
    localparam logic [CW-1:0] RCD_LD = CW'(T_RCDRD - 1);

    seq_st_e          st, st_n;
    logic [CW-1:0]    cnt, cnt_n;
    logic [BANK_W-1:0] tb_n;
    logic [ROW_W-1:0] tgt_row, tr_n;

    always_comb begin
        st_n     = st;
        cnt_n    = cnt;
        tb_n     = tgt_bank;
        tr_n     = tgt_row;
        nxt_cmd  = CMD_NOP;
        nxt_bank = tgt_bank;
        nxt_row  = tgt_row;
        case (st)
            SQ_IDLE: begin
                if (wr_valid) begin
                    if (open_i[wr_bank]) begin
                        nxt_cmd  = CMD_WRITE;
                        nxt_bank = wr_bank;
                        nxt_row  = rows_i[wr_bank];
                    end
                end else if (rd_valid) begin
                    tb_n  = rd_bank;
                    tr_n  = rd_row;
                    cnt_n = '0;
                    if (!open_i[rd_bank])                st_n = SQ_ACT;
                    else if (rows_i[rd_bank] == rd_row)  st_n = SQ_RD;
                    else                                 st_n = SQ_PRE;
                end
            end
            SQ_PRE: begin
                if (pre_ok) begin
                    nxt_cmd = CMD_PRE;
                    st_n    = SQ_ACT;
                    cnt_n   = RP_LD;
                end
            end
            SQ_ACT: begin
                if (cnt == '0) begin
                    nxt_cmd = CMD_ACT;
                    st_n    = SQ_RD;
                    cnt_n   = RCD_LD;
                end else begin
                    cnt_n = cnt - 1'b1;
                end
            end
            SQ_RD: begin
                if (cnt != '0) begin
                    cnt_n = cnt - 1'b1;
                end else if (rd_ok) begin
                    nxt_cmd = CMD_READ;
                    st_n    = SQ_IDLE;
                end
            end
            default: st_n = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= SQ_IDLE;
            cnt        <= '0;
            tgt_bank   <= '0;
            tgt_row    <= '0;
            cmd_q      <= CMD_NOP;
            cmd_bank_q <= '0;
            cmd_row_q  <= '0;
            issued_q   <= 1'b0;
        end else begin
            st         <= st_n;
            cnt        <= cnt_n;
            tgt_bank   <= tb_n;
            tgt_row    <= tr_n;
            cmd_q      <= nxt_cmd;
            cmd_bank_q <= nxt_bank;
            cmd_row_q  <= nxt_row;
            issued_q   <= (nxt_cmd == CMD_READ);
        end
    end

    assign busy = (st != SQ_IDLE);

    // Checker-only age counters: cycles since the last PRECHARGE and ACTIVE on the bus.
    logic [CW-1:0] pre_age, act_age;
    always_ff @(posedge clk) begin
        if (rst) begin
            pre_age <= CW'(CMAX);
            act_age <= CW'(CMAX);
        end else begin
            if (nxt_cmd == CMD_PRE)        pre_age <= '0;
            else if (int'(pre_age) < CMAX) pre_age <= pre_age + 1'b1;
            if (nxt_cmd == CMD_ACT)        act_age <= '0;
            else if (int'(act_age) < CMAX) act_age <= act_age + 1'b1;
        end
    end

    AST_PRE_TO_ACT: assert property (@(posedge clk) disable iff (rst)
        (cmd_q == CMD_ACT) |-> (int'(pre_age) >= T_RP))
        else $error("ACTIVE too soon after PRECHARGE"); // R6

    AST_ACT_TO_READ: assert property (@(posedge clk) disable iff (rst)
        (cmd_q == CMD_READ) |-> (int'(act_age) >= T_RCDRD))
        else $error("READ too soon after ACTIVE"); // R8

    AST_READ_ENDS_SEQ: assert property (@(posedge clk) disable iff (rst)
        (cmd_q == CMD_READ) |-> (!busy && issued_q))
        else $error("READ cycle with busy high or strobe low"); // R10

    AST_NO_WRITE_IN_SEQ: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cmd_q != CMD_WRITE))
        else $error("WRITE issued inside a read sequence"); // R9

endmodule

// File: rtl/ddr_w2r_seq.sv
module ddr_w2r_seq
    import ddr_w2r_pkg::*;
#(
    parameter int BANKS   = 4,
    parameter int ROW_W   = 12,
    parameter int BL      = 4,
    parameter int CL      = 2,
    parameter int T_WPD   = 4,
    parameter int T_RP    = 2,
    parameter int T_RCDRD = 2,
    localparam int BANK_W = $clog2(BANKS),
    localparam int TWRD   = wr2rd_gap(BL)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [BANK_W-1:0] wr_bank,
    input  logic              rd_valid,
    input  logic [BANK_W-1:0] rd_bank,
    input  logic [ROW_W-1:0]  rd_row,
    output logic              busy,
    output logic [2:0]        cmd,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_row,
    output logic              rd_issued,
    output logic              rd_data_win
);

    cmd_e                        nxt_cmd, cmd_q;
    logic [BANK_W-1:0]           nxt_bank, tgt_bank, cmd_bank_q;
    logic [ROW_W-1:0]            nxt_row, cmd_row_q;
    logic [BANKS-1:0]            open_v;
    logic [BANKS-1:0][ROW_W-1:0] rows_v;
    logic                        rd_ok, pre_ok, issued_q;

    w2r_seq_fsm #(
        .BANKS(BANKS), .ROW_W(ROW_W), .T_RP(T_RP), .T_RCDRD(T_RCDRD)
    ) u_fsm (
        .clk(clk), .rst(rst),
        .wr_valid(wr_valid), .wr_bank(wr_bank),
        .rd_valid(rd_valid), .rd_bank(rd_bank), .rd_row(rd_row),
        .open_i(open_v), .rows_i(rows_v),
        .rd_ok(rd_ok), .pre_ok(pre_ok),
        .nxt_cmd(nxt_cmd), .nxt_bank(nxt_bank), .nxt_row(nxt_row),
        .tgt_bank(tgt_bank),
        .cmd_q(cmd_q), .cmd_bank_q(cmd_bank_q), .cmd_row_q(cmd_row_q),
        .issued_q(issued_q), .busy(busy)
    );

    w2r_bank_table #(
        .BANKS(BANKS), .ROW_W(ROW_W)
    ) u_banks (
        .clk(clk), .rst(rst),
        .upd_cmd(nxt_cmd), .upd_bank(nxt_bank), .upd_row(nxt_row),
        .cmd_q(cmd_q), .cmd_bank_q(cmd_bank_q), .cmd_row_q(cmd_row_q),
        .open_o(open_v), .rows_o(rows_v)
    );

    w2r_write_track #(
        .BANK_W(BANK_W), .TWRD(TWRD), .T_WPD(T_WPD)
    ) u_wtrack (
        .clk(clk), .rst(rst),
        .wr_fire(nxt_cmd == CMD_WRITE), .wr_bank(nxt_bank),
        .tgt_bank(tgt_bank),
        .cmd_q(cmd_q), .cmd_bank_q(cmd_bank_q),
        .rd_ok(rd_ok), .pre_ok(pre_ok)
    );

    w2r_read_window #(
        .CL(CL), .BL(BL)
    ) u_rwin (
        .clk(clk), .rst(rst),
        .rd_fire(nxt_cmd == CMD_READ),
        .win(rd_data_win)
    );

    assign cmd       = cmd_q;
    assign cmd_bank  = cmd_bank_q;
    assign cmd_row   = cmd_row_q;
    assign rd_issued = issued_q;

endmodule

// File: tb/ddr_w2r_seq_bench.sv
module ddr_w2r_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int BANKS   = 4;
    localparam int ROW_W   = 12;
    localparam int BL      = 4;
    localparam int CL      = 2;
    localparam int T_WPD   = 4;
    localparam int T_RP    = 2;
    localparam int T_RCDRD = 2;
    localparam int GAP     = BL / 2 + 3;
    localparam int BW      = $clog2(BANKS);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_valid = 1'b0, rd_valid = 1'b0;
    logic [BW-1:0]    wr_bank = '0, rd_bank = '0;
    logic [ROW_W-1:0] rd_row = '0;
    logic             busy, rd_issued, rd_data_win;
    logic [2:0]       cmd;
    logic [BW-1:0]    cmd_bank;
    logic [ROW_W-1:0] cmd_row;

    ddr_w2r_seq #(
        .BANKS(BANKS), .ROW_W(ROW_W), .BL(BL), .CL(CL),
        .T_WPD(T_WPD), .T_RP(T_RP), .T_RCDRD(T_RCDRD)
    ) u_ddr_w2r_seq (
        .clk(clk), .rst(rst),
        .wr_valid(wr_valid), .wr_bank(wr_bank),
        .rd_valid(rd_valid), .rd_bank(rd_bank), .rd_row(rd_row),
        .busy(busy), .cmd(cmd), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
        .rd_issued(rd_issued), .rd_data_win(rd_data_win)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Behavioural timeline model: absolute cycle stamps for every expected command.
    typedef struct {
        int    t;
        int    c;
        int    b;
        int    r;
        string tag;
    } ev_t;

    ev_t   evq[$];
    int    rd_hist[$];
    int    cyc = 0;
    bit    m_open[BANKS];
    int    m_row[BANKS];
    int    tw = -1000;
    int    wb = 0;
    int    e_cmd = 0, e_bank = 0, e_row = 0;
    bit    e_busy = 0, e_iss = 0, e_win = 0;
    string e_tag = "R1";

    function automatic void push_ev(input int t, input int c, input int b,
                                    input int r, input string tag);
        ev_t e;
        e.t = t; e.c = c; e.b = b; e.r = r; e.tag = tag;
        evq.push_back(e);
    endfunction

    function automatic void schedule(input int c, input int b, input int r);
        int    t_act, t_rd, t_pre;
        string rtag, ptag;
        if (!m_open[b]) begin
            t_act = c + 1;
            push_ev(t_act, 3, b, r, "R8 R12");
            t_rd = t_act + T_RCDRD;
            rtag = "R8";
        end else if (m_row[b] == r) begin
            t_rd = c + 1;
            rtag = "R4 R12";
        end else begin
            t_pre = c + 1;
            ptag  = "R7 R12";
            if (b == wb) begin
                if (tw + T_WPD > t_pre) t_pre = tw + T_WPD;
                ptag = "R5 R12";
            end
            push_ev(t_pre, 4, b, r, ptag);
            t_act = t_pre + T_RP;
            push_ev(t_act, 3, b, r, "R6");
            t_rd = t_act + T_RCDRD;
            rtag = "R6";
        end
        if (tw + GAP > t_rd) begin
            t_rd = tw + GAP;
            rtag = "R3";
        end
        push_ev(t_rd, 2, b, r, rtag);
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            evq.delete();
            rd_hist.delete();
            foreach (m_open[i]) begin m_open[i] = 0; m_row[i] = 0; end
            tw = -1000; wb = 0;
            e_cmd = 0; e_busy = 0; e_iss = 0; e_win = 0; e_tag = "R1";
        end else begin
            e_cmd = 0;
            e_tag = "R9";
            if (evq.size() == 0) begin
                if (wr_valid) begin
                    e_tag = "R2";
                    if (m_open[wr_bank]) begin
                        e_cmd = 1; e_bank = wr_bank; e_row = m_row[wr_bank];
                        tw = cyc; wb = wr_bank;
                    end
                end else if (rd_valid) begin
                    schedule(cyc, rd_bank, rd_row);
                end
            end else if (evq[0].t == cyc) begin
                e_cmd = evq[0].c; e_bank = evq[0].b; e_row = evq[0].r;
                e_tag = evq[0].tag;
                if (e_cmd == 4) m_open[e_bank] = 0;
                if (e_cmd == 3) begin m_open[e_bank] = 1; m_row[e_bank] = e_row; end
                void'(evq.pop_front());
            end
            e_iss = (e_cmd == 2);
            if (e_iss) rd_hist.push_back(cyc);
            while (rd_hist.size() > 0 && cyc - rd_hist[0] > CL + BL / 2)
                void'(rd_hist.pop_front());
            e_win = 0;
            foreach (rd_hist[i])
                if (cyc - rd_hist[i] >= CL && cyc - rd_hist[i] <= CL + BL / 2 - 1) e_win = 1;
            e_busy = (evq.size() != 0);
        end
    end

    always @(negedge clk) begin
        if (cyc > 0 && !done) begin
            string aux;
            aux = (e_tag == "R1") ? "R1" : "R9";
            chk(int'(cmd) == e_cmd, e_tag, "cmd", int'(cmd), e_cmd);
            if (e_cmd != 0)
                chk(int'(cmd_bank) == e_bank, e_tag, "cmd_bank", int'(cmd_bank), e_bank);
            if (e_cmd == 1 || e_cmd == 2 || e_cmd == 3)
                chk(int'(cmd_row) == e_row, e_tag, "cmd_row", int'(cmd_row), e_row);
            chk(busy == e_busy, aux, "busy", busy, e_busy);
            chk(rd_issued == e_iss, (aux == "R1") ? "R1" : "R10", "rd_issued", rd_issued, e_iss);
            chk(rd_data_win == e_win, (aux == "R1") ? "R1" : "R11", "rd_data_win", rd_data_win, e_win);
        end
    end

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    task automatic pulse_wr(input int b);
        wr_valid = 1'b1; wr_bank = BW'(b);
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic pulse_rd(input int b, input int r);
        rd_valid = 1'b1; rd_bank = BW'(b); rd_row = ROW_W'(r);
        @(negedge clk);
        rd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (e_busy) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        pulse_wr(1);                       // R2: idle bank, ignored
        idle(2);
        pulse_rd(1, 5); wait_idle();       // R8: idle bank
        pulse_rd(2, 7); wait_idle();       // R8
        pulse_wr(1); pulse_rd(1, 5); wait_idle();   // R3 R4: hit gated by write gap
        pulse_wr(1); pulse_rd(1, 9); wait_idle();   // R5 R6: miss on written bank
        pulse_wr(1); pulse_rd(2, 3); wait_idle();   // R7: miss on other bank
        pulse_wr(2); pulse_rd(1, 9); wait_idle();   // R3: other bank hit
        pulse_rd(3, 1); pulse_rd(0, 2); pulse_wr(1); wait_idle();  // R9: dropped while busy
        idle(3);
        wr_valid = 1'b1; wr_bank = 2'd3; rd_valid = 1'b1; rd_bank = 2'd3; rd_row = 12'd1;
        @(negedge clk);                    // R2: write wins over read
        wr_valid = 1'b0; rd_valid = 1'b0;
        idle(8);
        pulse_rd(1, 9); wait_idle();       // R4: back-to-back hits, R11 windows
        pulse_rd(1, 9); wait_idle();
        pulse_wr(2); idle(10); pulse_rd(2, 3); wait_idle();  // R3 exceeded: READ right away
        pulse_rd(0, 2); wait_idle();       // R8 R12: bank 0 still idle after dropped request
        idle(8);
        done = 1;
        report();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL R9 watchdog: actual %0d expected %0d", 1, 0);
            report();
            $finish;
        end
    end

endmodule